// File: doc/BRIEF.md
# AES Column Mixing Unit (forward and inverse)

This unit transforms one 32-bit column of the AES state. With the mode input low it computes MixColumns. With the mode input high it first adjusts the column with a small stage built from multiples of 04, then runs the same forward network, and the result is InvMixColumns. The only arithmetic used is xtime (multiply by 02 in GF(2^8)) and XOR. No multipliers for the constants 09, 0B, 0D or 0E are needed.

The unit is purely combinational and holds no state. A round datapath places one copy per column, or a single copy that is time-shared across the four columns. ShiftRows, SubBytes and the key schedule belong to the surrounding datapath.

Top module: `mixcol_unit`

## Requirements
- R1: Byte k of a column (k = 0..3) sits at bits [31-8k : 24-8k] on both the input and the output.
- R2: With `inv_sel` = 0, output byte i equals 02·a_i ^ 03·a_((i+1) mod 4) ^ a_((i+2) mod 4) ^ a_((i+3) mod 4).
- R3: Multiplication by 02 is a one-bit left shift, followed by XOR with 0x1B when bit 7 of the operand is set. This is reduction modulo x^8+x^4+x^3+x+1.
- R4: With `inv_sel` = 1, output byte i equals 0E·a_i ^ 0B·a_(i+1) ^ 0D·a_(i+2) ^ 09·a_(i+3), indices mod 4.
- R5: Applying the inverse mode to the forward-mode output returns the original column, and the reverse order also returns it.
- R6: The column db 13 53 45 maps to 8e 4d a1 bc in forward mode, and back again in inverse mode.
- R7: In both modes, a column of four equal bytes, including all zeros, passes through unchanged.
- R8: In both modes, the XOR of the four output bytes equals the XOR of the four input bytes.
- R9: The output depends only on the current inputs and is valid in the same cycle. There is no clock or latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inv_sel | input | 1 | 0 selects MixColumns, 1 selects InvMixColumns |
| col_in | input | 32 | Input column, byte 0 in the top byte |
| col_out | output | 32 | Transformed column, byte 0 in the top byte |

## Verification
The unit holds no state, so a fault in an xtime cell, the adjusting stage or the mixing network appears on `col_out` for the very input that exercises it. It appears in the same evaluation, with no delay. A wrong reduction constant only shows when an operand has bit 7 set. A wrong pairing in the adjusting stage only shows in inverse mode, and only when opposite bytes differ. For this reason the stimulus covers both modes, high-bit bytes and unequal opposite pairs. Round trips through both modes expose any error that breaks invertibility.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
    localparam int BYTE_W   = 8;
    localparam int NBYTES   = 4;
    localparam int COL_W    = BYTE_W * NBYTES;
    localparam logic [BYTE_W-1:0] RED_CONST = 8'h1B;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/mixcol_xtime.sv
module mixcol_xtime
    import mixcol_pkg::*;
(
    input  byte_t a,
    output byte_t y
);
    // shift left, fold bit 7 back through the reduction constant
    always_comb begin
        y = {a[BYTE_W-2:0], 1'b0} ^ (RED_CONST & {BYTE_W{a[BYTE_W-1]}});
    end
endmodule

// File: rtl/mixcol_pre.sv
module mixcol_pre
    import mixcol_pkg::*;
(
    input  logic             inv_sel,
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_out
);
    localparam int NPAIRS = NBYTES / 2;

    byte_t b   [NBYTES];
    byte_t dlt [NPAIRS];

    for (genvar k = 0; k < NBYTES; k++) begin : g_split
        assign b[k] = col_in[COL_W-1-BYTE_W*k -: BYTE_W];
    end

    // one x04 term per pair of opposite bytes: two chained xtime cells
    for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
        byte_t sum_p, x2_p;
        assign sum_p = b[p] ^ b[p+NPAIRS];
        mixcol_xtime u_x2 (.a(sum_p), .y(x2_p));
        mixcol_xtime u_x4 (.a(x2_p),  .y(dlt[p]));
    end

    for (genvar k = 0; k < NBYTES; k++) begin : g_join
        assign col_out[COL_W-1-BYTE_W*k -: BYTE_W] =
            b[k] ^ (dlt[k % NPAIRS] & {BYTE_W{inv_sel}});
    end
endmodule

// File: rtl/mixcol_fwd.sv
module mixcol_fwd
    import mixcol_pkg::*;
(
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_out
);
    byte_t b [NBYTES];

    for (genvar k = 0; k < NBYTES; k++) begin : g_split
        assign b[k] = col_in[COL_W-1-BYTE_W*k -: BYTE_W];
    end

    // 02*a_i ^ 03*a_{i+1} = 02*(a_i ^ a_{i+1}) ^ a_{i+1}
    for (genvar i = 0; i < NBYTES; i++) begin : g_row
        byte_t pair_i, dbl_i;
        assign pair_i = b[i] ^ b[(i+1) % NBYTES];
        mixcol_xtime u_dbl (.a(pair_i), .y(dbl_i));
        assign col_out[COL_W-1-BYTE_W*i -: BYTE_W] =
            dbl_i ^ b[(i+1) % NBYTES] ^ b[(i+2) % NBYTES] ^ b[(i+3) % NBYTES];
    end
endmodule

// File: rtl/mixcol_unit.sv
module mixcol_unit
    import mixcol_pkg::*;
(
    input  logic             inv_sel,
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_out
);
    logic [COL_W-1:0] pre_col;

    mixcol_pre u_pre (
        .inv_sel (inv_sel),
        .col_in  (col_in),
        .col_out (pre_col)
    );

    mixcol_fwd u_fwd (
        .col_in  (pre_col),
        .col_out (col_out)
    );
endmodule

// File: rtl/mixcol_unit_chk.sv
module mixcol_unit_chk
    import mixcol_pkg::*;
(
    input logic             inv_sel,
    input logic [COL_W-1:0] col_in,
    input logic [COL_W-1:0] col_out,
    input logic [COL_W-1:0] pre_col
);
    function automatic byte_t fold(input logic [COL_W-1:0] c);
        byte_t r = '0;
        for (int k = 0; k < NBYTES; k++) r ^= c[BYTE_W*k +: BYTE_W];
        return r;
    endfunction

    always_comb begin
        if (!$isunknown({inv_sel, col_in, col_out, pre_col})) begin
            // R2: the adjusting stage is transparent in forward mode
            p_fwd_bypass_r2: assert (inv_sel || pre_col == col_in);
            // R7: all-zero column stays zero
            p_zero_col_r7: assert (col_in != '0 || col_out == '0);
            // R7: four equal bytes pass unchanged
            p_uniform_col_r7: assert (!(col_in[31:24] == col_in[23:16] &&
                                        col_in[23:16] == col_in[15:8] &&
                                        col_in[15:8]  == col_in[7:0]) ||
                                      col_out == col_in);
            // R8: byte-wise XOR of the column is preserved
            p_fold_keep_r8: assert (fold(col_out) == fold(col_in));
        end
    end
endmodule

bind mixcol_unit mixcol_unit_chk u_chk (
    .inv_sel (inv_sel),
    .col_in  (col_in),
    .col_out (col_out),
    .pre_col (pre_col)
);

// File: tb/mixcol_unit_tb.sv
module mixcol_unit_tb;
    logic        clk = 1'b0;
    logic        inv_sel;
    logic [31:0] col_in;
    logic [31:0] col_out;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #10 clk = ~clk;

    mixcol_unit u_dut (.inv_sel(inv_sel), .col_in(col_in), .col_out(col_out));

    // behavioural GF(2^8) product, shift-and-add
    function automatic logic [7:0] gmul(input logic [7:0] x, input logic [7:0] y);
        logic [7:0] acc = 8'h00;
        logic [7:0] aa  = x;
        logic [7:0] bb  = y;
        for (int n = 0; n < 8; n++) begin
            if (bb[0]) acc ^= aa;
            if (aa[7]) aa = (aa << 1) ^ 8'h1B;
            else       aa = aa << 1;
            bb = bb >> 1;
        end
        return acc;
    endfunction

    function automatic logic [31:0] ref_model(input logic m, input logic [31:0] c);
        logic [7:0] a [4];
        logic [7:0] k [4];
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) a[i] = c[31-8*i -: 8];
        if (m) begin k[0]=8'h0E; k[1]=8'h0B; k[2]=8'h0D; k[3]=8'h09; end
        else   begin k[0]=8'h02; k[1]=8'h03; k[2]=8'h01; k[3]=8'h01; end
        for (int i = 0; i < 4; i++) begin
            logic [7:0] s = 8'h00;
            for (int j = 0; j < 4; j++) s ^= gmul(k[j], a[(i+j)%4]);
            r[31-8*i -: 8] = s;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] exp);
        checks++;
        if (col_out !== exp) begin
            errors++;
            $display("FAIL %s mode=%0d in=%08h actual=%08h expected=%08h",
                     tag, inv_sel, col_in, col_out, exp);
        end
    endtask

    // drive after a rising edge, sample at the following falling edge
    task automatic apply(input logic m, input logic [31:0] c);
        @(posedge clk); #1;
        inv_sel = m;
        col_in  = c;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] mid;
        inv_sel = 1'b0; col_in = '0;
        // R7, R9: zero column in both modes, valid in the same cycle
        apply(1'b0, 32'h0); check("R7 zero fwd", 32'h0);
        apply(1'b1, 32'h0); check("R7 zero inv R9", 32'h0);
        // R7: uniform columns
        apply(1'b0, 32'h01010101); check("R7 uniform fwd", 32'h01010101);
        apply(1'b1, 32'hC6C6C6C6); check("R7 uniform inv", 32'hC6C6C6C6);
        // R6, R1: known column and its byte placement
        apply(1'b0, 32'hDB135345); check("R6 known fwd R1", 32'h8E4DA1BC);
        apply(1'b1, 32'h8E4DA1BC); check("R6 known inv", 32'hDB135345);
        // R3: single high bit exercises the reduction
        apply(1'b0, 32'h80000000); check("R3 reduce fwd", ref_model(1'b0, 32'h80000000));
        apply(1'b1, 32'h00800000); check("R3 reduce inv", ref_model(1'b1, 32'h00800000));
        apply(1'b0, 32'hF20A225C); check("R2 vector", 32'h9FDC589D);
        // R2, R4, R8: random columns against the model, both modes
        for (int t = 0; t < 300; t++) begin
            logic [31:0] c = $urandom;
            apply(1'b0, c); check("R2 random fwd R8", ref_model(1'b0, c));
            apply(1'b1, c); check("R4 random inv R8", ref_model(1'b1, c));
        end
        // R5: round trips both ways
        for (int t = 0; t < 200; t++) begin
            logic [31:0] c = $urandom;
            apply(1'b0, c); mid = col_out;
            apply(1'b1, mid); check("R5 fwd then inv", c);
            apply(1'b1, c); mid = col_out;
            apply(1'b0, mid); check("R5 inv then fwd", c);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule